// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This block steps a small system-on-chip through five power modes by driving one clock enable per clock domain and one clock-source select. Software writes three registers through a simple write port: a mode request, a mask that switches single blocks' clocks on or off, and the length of the PLL lock wait used when the chip wakes up.

The enables for each mode come from a fixed table. The mask is then ANDed into them, so a mask bit can only remove a clock and never adds one. The deepest mode stops every clock and takes no further mode writes. Only the eight external wake lines or the RTC alarm bring the chip out of it. The chip then waits with every clock off until the PLL reports lock, or until the programmed wait runs out. After that it returns to normal operation. The CPU-only idle mode ends on any pending enabled interrupt. The display-only idle mode ends on a pending interrupt or on a wake source.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the block is in normal mode with the mask set to all ones, so `cpu_clk_en`, `lcd_clk_en`, every bit of `per_clk_en` and `sel_pll` read 1.
- R2: A write to address 0 asks for a mode through `reg_wdata[2:0]`: 0 normal, 1 slow, 2 CPU-only idle, 3 stop, 4 display-only idle. The new mode shows on the outputs right after the clock edge that samples the write.
- R3: A write to address 0 with a code of 5, 6 or 7 leaves the mode and all outputs unchanged.
- R4: In normal mode `cpu_clk_en` is 1, the display and peripheral enables follow the mask, and `sel_pll` is 1 (PLL clock).
- R5: In slow mode `sel_pll` is 0 (slow reference clock), `cpu_clk_en` is 1, and the display and peripheral enables follow the mask.
- R6: CPU-only idle drives `cpu_clk_en` to 0 while the display and peripheral enables still follow the mask and `sel_pll` stays 1. A high `irq_pend` at a clock edge returns the block to normal.
- R7: Stop mode drives every enable and `sel_pll` to 0, and mode writes made while stopped are ignored.
- R8: Display-only idle sets `cpu_clk_en` and all of `per_clk_en` to 0. `lcd_clk_en` follows mask bit 8 and `sel_pll` stays 1. A high `irq_pend`, any `wake_ext` bit or `rtc_alarm` at a clock edge returns the block to normal.
- R9: In stop mode, any high `wake_ext` bit or a high `rtc_alarm` at a clock edge moves the block into a lock-wait phase. In that phase every enable and `sel_pll` stay 0.
- R10: The lock-wait phase ends at the first clock edge where `pll_locked` is high. With the PLL unlocked it ends after wait value + 1 cycles. It always ends in normal mode.
- R11: A write to address 1 loads the mask: `reg_wdata[7:0]` are the peripheral enables and `reg_wdata[8]` the display enable. Each output enable is the AND of its mask bit and the enable of the current mode.
- R12: A write to address 2 loads the lock-wait count from `reg_wdata[15:0]`. It is used the next time the block leaves stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 mode, 1 mask, 2 lock wait |
| reg_wdata | input | 16 | Write data |
| wake_ext | input | 8 | External wake lines, active high |
| rtc_alarm | input | 1 | RTC alarm wake, active high |
| irq_pend | input | 1 | Any enabled interrupt pending |
| pll_locked | input | 1 | PLL lock indication |
| cpu_clk_en | output | 1 | CPU clock enable |
| lcd_clk_en | output | 1 | Display controller clock enable |
| per_clk_en | output | 8 | Bus/peripheral clock enables |
| sel_pll | output | 1 | 1 selects the PLL clock, 0 the slow reference |

## Verification
The assertions assume that the wake lines, the RTC alarm, `irq_pend` and `pll_locked` are already synchronous to `clk` and stable around each rising edge. They also assume that a register write lasts exactly one cycle. The bench changes every input only on the falling edge and gives each write a one-cycle strobe. It also raises the wake and interrupt inputs only in the modes where they are expected to act, so every assertion precondition is met by legal stimulus alone.

// File: rtl/pwr_clk_pkg.sv
// Shared types for the power mode clock controller.
// Encodings 0..4 match the software mode codes; PM_WAKE is internal only.
package pwr_clk_pkg;
    typedef enum logic [2:0] {
        PM_NORMAL = 3'd0,
        PM_SLOW   = 3'd1,
        PM_IDLE   = 3'd2,
        PM_STOP   = 3'd3,
        PM_DISP   = 3'd4,
        PM_WAKE   = 3'd5
    } pm_state_e;

    localparam logic [2:0] PM_MAX_CODE = 3'd4;
endpackage

// File: rtl/pwr_regs.sv
// Software register file: clock mask, lock-wait count and mode request decode.
// Assumes a one-cycle write strobe; DW must be at least NPER+1 and LOCK_W wide.
module pwr_regs
    import pwr_clk_pkg::*;
#(
    parameter int NPER     = 8,
    parameter int DW       = 16,
    parameter int LOCK_W   = 16,
    parameter int LOCK_RST = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [NPER:0]     mask_q,
    output logic [LOCK_W-1:0] lock_wait_q,
    output logic              mode_req_vld,
    output pm_state_e         mode_req
);
    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_MASK = 2'd1;
    localparam logic [1:0] A_LOCK = 2'd2;

    // Decode a legal mode request; undefined codes never reach the FSM.
    always_comb begin
        mode_req     = pm_state_e'(reg_wdata[2:0]);
        mode_req_vld = reg_wr && (reg_addr == A_MODE) && (reg_wdata[2:0] <= PM_MAX_CODE);
    end

    // Hold the mask and the lock-wait count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q      <= '1;
            lock_wait_q <= LOCK_W'(LOCK_RST);
        end else if (reg_wr) begin
            if (reg_addr == A_MASK) mask_q      <= reg_wdata[NPER:0];
            if (reg_addr == A_LOCK) lock_wait_q <= reg_wdata[LOCK_W-1:0];
        end
    end
endmodule

// File: rtl/pwr_mode_fsm.sv
// Power mode sequencer with the post-stop lock-wait counter.
// Assumes wake, interrupt and lock inputs are synchronous to clk.
module pwr_mode_fsm
    import pwr_clk_pkg::*;
#(
    parameter int LOCK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_req_vld,
    input  pm_state_e         mode_req,
    input  logic              wake_any,
    input  logic              irq_pend,
    input  logic              pll_locked,
    input  logic [LOCK_W-1:0] lock_wait,
    output pm_state_e         state_q
);
    pm_state_e         state_d;
    logic [LOCK_W-1:0] cnt_q;
    logic              cnt_done;

    assign cnt_done = (cnt_q == '0);

    // Next-mode selection; exit events take priority over software requests.
    always_comb begin
        state_d = state_q;
        case (state_q)
            PM_NORMAL, PM_SLOW: if (mode_req_vld) state_d = mode_req;
            PM_IDLE: begin
                if (irq_pend)          state_d = PM_NORMAL;
                else if (mode_req_vld) state_d = mode_req;
            end
            PM_DISP: begin
                if (irq_pend || wake_any) state_d = PM_NORMAL;
                else if (mode_req_vld)    state_d = mode_req;
            end
            PM_STOP: if (wake_any) state_d = PM_WAKE;
            PM_WAKE: if (pll_locked || cnt_done) state_d = PM_NORMAL;
            default: state_d = PM_NORMAL;
        endcase
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_NORMAL;
        else        state_q <= state_d;
    end

    // Lock-wait counter: loaded when stop is left, counts down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cnt_q <= '0;
        else if (state_q == PM_STOP && wake_any)   cnt_q <= lock_wait;
        else if (state_q == PM_WAKE && !cnt_done)  cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/pwr_gate_map.sv
// Maps the current mode to clock enables and the source select, then applies the mask.
// Purely combinational; the mask can only remove clocks.
module pwr_gate_map
    import pwr_clk_pkg::*;
#(
    parameter int NPER = 8
) (
    input  pm_state_e       state,
    input  logic [NPER:0]   mask,
    output logic            cpu_clk_en,
    output logic            lcd_clk_en,
    output logic [NPER-1:0] per_clk_en,
    output logic            sel_pll
);
    logic cpu_on, lcd_on, per_on;

    // Per-mode domain table.
    always_comb begin
        cpu_on  = 1'b0;
        lcd_on  = 1'b0;
        per_on  = 1'b0;
        sel_pll = 1'b0;
        case (state)
            PM_NORMAL: begin cpu_on = 1'b1; lcd_on = 1'b1; per_on = 1'b1; sel_pll = 1'b1; end
            PM_SLOW:   begin cpu_on = 1'b1; lcd_on = 1'b1; per_on = 1'b1; end
            PM_IDLE:   begin lcd_on = 1'b1; per_on = 1'b1; sel_pll = 1'b1; end
            PM_DISP:   begin lcd_on = 1'b1; sel_pll = 1'b1; end
            default:   ;
        endcase
    end

    assign cpu_clk_en = cpu_on;
    assign lcd_clk_en = lcd_on & mask[NPER];

    // One AND gate per peripheral domain.
    for (genvar i = 0; i < NPER; i++) begin : g_per
        assign per_clk_en[i] = per_on & mask[i];
    end
endmodule

// File: rtl/pwr_clk_ctrl.sv
// Top of the power mode clock gating controller.
// Assumes all asynchronous wake sources are synchronised before reaching it.
module pwr_clk_ctrl
    import pwr_clk_pkg::*;
#(
    parameter int NPER     = 8,
    parameter int NWAKE    = 8,
    parameter int DW       = 16,
    parameter int LOCK_W   = 16,
    parameter int LOCK_RST = 255
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [1:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic [NWAKE-1:0] wake_ext,
    input  logic            rtc_alarm,
    input  logic            irq_pend,
    input  logic            pll_locked,
    output logic            cpu_clk_en,
    output logic            lcd_clk_en,
    output logic [NPER-1:0] per_clk_en,
    output logic            sel_pll
);
    logic [NPER:0]     mask_q;
    logic [LOCK_W-1:0] lock_wait_q;
    logic              mode_req_vld;
    pm_state_e         mode_req;
    pm_state_e         state_q;
    logic              wake_any;

    assign wake_any = (|wake_ext) | rtc_alarm;

    pwr_regs #(.NPER(NPER), .DW(DW), .LOCK_W(LOCK_W), .LOCK_RST(LOCK_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .mask_q(mask_q), .lock_wait_q(lock_wait_q),
        .mode_req_vld(mode_req_vld), .mode_req(mode_req)
    );

    pwr_mode_fsm #(.LOCK_W(LOCK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .mode_req_vld(mode_req_vld), .mode_req(mode_req),
        .wake_any(wake_any), .irq_pend(irq_pend), .pll_locked(pll_locked),
        .lock_wait(lock_wait_q), .state_q(state_q)
    );

    pwr_gate_map #(.NPER(NPER)) u_map (
        .state(state_q), .mask(mask_q), .cpu_clk_en(cpu_clk_en),
        .lcd_clk_en(lcd_clk_en), .per_clk_en(per_clk_en), .sel_pll(sel_pll)
    );
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
// Property checker for pwr_clk_ctrl, attached by bind.
// Assumes synchronous inputs and one-cycle write strobes.
module pwr_clk_ctrl_chk
    import pwr_clk_pkg::*;
#(
    parameter int NPER  = 8,
    parameter int NWAKE = 8,
    parameter int DW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [DW-1:0]    reg_wdata,
    input logic [NWAKE-1:0] wake_ext,
    input logic             rtc_alarm,
    input logic             irq_pend,
    input logic             pll_locked,
    input pm_state_e        state_q,
    input logic [NPER:0]    mask_q,
    input logic             cpu_clk_en,
    input logic             lcd_clk_en,
    input logic [NPER-1:0]  per_clk_en,
    input logic             sel_pll
);
    logic wake_any;
    assign wake_any = (|wake_ext) | rtc_alarm;

    AST_MASK_ONLY_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        ((per_clk_en & ~mask_q[NPER-1:0]) == '0) && !(lcd_clk_en && !mask_q[NPER])); // R11
    AST_UNDEF_CODE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_NORMAL && reg_wr && reg_addr == 2'd0 && reg_wdata[2:0] > PM_MAX_CODE)
        |=> state_q == PM_NORMAL); // R3
    AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PM_STOP |-> !cpu_clk_en && !lcd_clk_en && per_clk_en == '0 && !sel_pll); // R7
    AST_STOP_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_STOP && wake_any) |=> state_q == PM_WAKE); // R9
    AST_WAKE_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PM_WAKE |-> !cpu_clk_en && !lcd_clk_en && per_clk_en == '0 && !sel_pll); // R9
    AST_LOCK_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_WAKE && pll_locked) |=> state_q == PM_NORMAL); // R10
    AST_IDLE_IRQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_IDLE && irq_pend) |=> state_q == PM_NORMAL && cpu_clk_en); // R6
    AST_SLOW_USES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PM_SLOW |-> !sel_pll && cpu_clk_en); // R5
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.NPER(NPER), .NWAKE(NWAKE), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wake_ext(wake_ext), .rtc_alarm(rtc_alarm),
    .irq_pend(irq_pend), .pll_locked(pll_locked), .state_q(state_q),
    .mask_q(mask_q), .cpu_clk_en(cpu_clk_en), .lcd_clk_en(lcd_clk_en),
    .per_clk_en(per_clk_en), .sel_pll(sel_pll)
);

// File: tb/sim_pwr_clk_ctrl.sv
// Directed bench for pwr_clk_ctrl: one task per scenario, 50 MHz clock.
module sim_pwr_clk_ctrl;
    localparam int NPER = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [7:0]  wake_ext = '0;
    logic        rtc_alarm = 1'b0;
    logic        irq_pend = 1'b0;
    logic        pll_locked = 1'b0;
    logic        cpu_clk_en, lcd_clk_en, sel_pll;
    logic [7:0]  per_clk_en;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pwr_clk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wake_ext(wake_ext), .rtc_alarm(rtc_alarm),
        .irq_pend(irq_pend), .pll_locked(pll_locked), .cpu_clk_en(cpu_clk_en),
        .lcd_clk_en(lcd_clk_en), .per_clk_en(per_clk_en), .sel_pll(sel_pll)
    );

    // Packed view {cpu, lcd, sel_pll, per}.
    function automatic logic [10:0] pk(input logic c, input logic l, input logic s, input logic [7:0] p);
        return {c, l, s, p};
    endfunction

    task automatic check(input string req, input logic [10:0] exp);
        logic [10:0] got;
        got = {cpu_clk_en, lcd_clk_en, sel_pll, per_clk_en};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset", pk(1, 1, 1, 8'hFF));
    endtask

    task automatic t_mask;
        wr(2'd1, 16'h00A5);
        check("R11 mask display off", pk(1, 0, 1, 8'hA5));
        wr(2'd1, 16'h015A);
        check("R4 normal follows mask", pk(1, 1, 1, 8'h5A));
    endtask

    task automatic t_slow;
        wr(2'd0, 16'd1);
        check("R5 R2 slow", pk(1, 1, 0, 8'h5A));
        wr(2'd0, 16'd7);
        check("R3 undefined code in slow", pk(1, 1, 0, 8'h5A));
        wr(2'd0, 16'd0);
        check("R2 back to normal", pk(1, 1, 1, 8'h5A));
        wr(2'd0, 16'd5);
        check("R3 undefined code in normal", pk(1, 1, 1, 8'h5A));
    endtask

    task automatic t_idle;
        wr(2'd0, 16'd2);
        check("R6 idle gates cpu", pk(0, 1, 1, 8'h5A));
        @(negedge clk); irq_pend = 1'b1;
        @(negedge clk); irq_pend = 1'b0;
        check("R6 irq ends idle", pk(1, 1, 1, 8'h5A));
    endtask

    task automatic t_disp;
        wr(2'd0, 16'd4);
        check("R8 display only", pk(0, 1, 1, 8'h00));
        @(negedge clk); wake_ext = 8'h20;
        @(negedge clk); wake_ext = '0;
        check("R8 wake ends display idle", pk(1, 1, 1, 8'h5A));
    endtask

    task automatic t_stop_lock;
        wr(2'd2, 16'd10);
        wr(2'd0, 16'd3);
        check("R7 stop all off", pk(0, 0, 0, 8'h00));
        wr(2'd0, 16'd0);
        check("R7 write ignored in stop", pk(0, 0, 0, 8'h00));
        @(negedge clk); rtc_alarm = 1'b1;
        @(negedge clk); rtc_alarm = 1'b0;
        check("R9 rtc wake, clocks held", pk(0, 0, 0, 8'h00));
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check("R10 waiting for lock", pk(0, 0, 0, 8'h00));
        end
        pll_locked = 1'b1;
        @(negedge clk); pll_locked = 1'b0;
        check("R10 lock ends wait", pk(1, 1, 1, 8'h5A));
    endtask

    task automatic t_stop_count;
        wr(2'd2, 16'd3);
        wr(2'd0, 16'd3);
        @(negedge clk); wake_ext = 8'h01;
        @(negedge clk); wake_ext = '0;
        check("R9 wake line leaves stop", pk(0, 0, 0, 8'h00));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R12 R10 counting lock wait", pk(0, 0, 0, 8'h00));
        end
        @(negedge clk);
        check("R12 R10 wait expired", pk(1, 1, 1, 8'h5A));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_slow();
        t_idle();
        t_disp();
        t_stop_lock();
        t_stop_count();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule